// File: doc/BRIEF.md
# Alias-Aware Memory Protection Filter

This block guards a small register unit whose 4 KB window repeats four times across a 16 KB span. The unit's decoder ignores address bits 13:12, so each register answers at four addresses. The filter sits on the request path in front of that unit. It folds every incoming address to its 12-bit canonical offset before it applies the access policy. A mirrored address therefore always gets the same decision as its primary address, or a stricter one.

Requests use a valid/ready channel that carries an address, a write flag, write data and a trust bit. A rejected request completes in the cycle it is presented, with an error flag and zeroed read data. An accepted request is passed to the target with the folded offset, and the target's read data comes back in the same cycle. A configuration port sets the policy: a protected offset range, separate read and write permissions for untrusted requesters, the mirror controls and the mapped window size. The port accepts writes only from a trusted requester.

Top module: `mpf_top`

## Requirements
- R1: Address bits 11:0 form the canonical offset, and an accepted request reaches the target with exactly that offset. When mirroring is enabled and blocking is off, the four addresses that differ only in bits 13:12 get the same decision.
- R2: An untrusted request is in the protected range when its canonical offset lies between the base (select 0) and the limit (select 1), both bounds included. If the base is above the limit, nothing is protected.
- R3: In the protected range, an untrusted read is allowed only if read-allow (select 2, bit 0) is set, and an untrusted write is allowed only if write-allow (select 2, bit 1) is set. Trusted requests skip this check.
- R4: When mirror blocking (select 3, bit 1) is set, an untrusted request with bits 13:12 nonzero is rejected, whatever the policy for the primary range.
- R5: When mirror enable (select 3, bit 0) is clear, every request with bits 13:12 nonzero is rejected, trusted requests included.
- R6: A request whose canonical offset is above the last mapped offset (select 4) is rejected for every requester. It does not wrap onto a lower register.
- R7: A rejected request has req_ready high, rsp_valid high, rsp_err high and rsp_rdata zero in the cycle it is presented. No target request is raised.
- R8: An accepted request raises tgt_valid with the request's write flag and write data. Both req_ready and rsp_valid follow tgt_ready, rsp_err is low and rsp_rdata equals tgt_rdata.
- R9: A configuration write with cfg_trusted high takes effect from the next clock edge. A write with cfg_trusted low changes nothing, including the mirror controls and the window size. Select codes 5 to 7 are ignored.
- R10: After reset the filter is fully locked: mirroring disabled, blocking set, base 0, limit 0xFFF, last mapped offset 0xFFF, and untrusted read and write both denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 14 | Byte address within the 16 KB span |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_trusted | input | 1 | Requester is trusted |
| rsp_valid | output | 1 | Response for the request accepted this cycle |
| rsp_rdata | output | 32 | Read data, zero on error |
| rsp_err | output | 1 | Access rejected |
| tgt_valid | output | 1 | Request forwarded to the register unit |
| tgt_ready | input | 1 | Register unit accepts the forwarded request |
| tgt_offset | output | 12 | Canonical offset sent to the unit |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_rdata | input | 32 | Read data from the unit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_trusted | input | 1 | Configuration writer is trusted |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | 12 | Configuration value |

## Verification
Request-side decisions are combinational, so a wrong decode shows up at the ports in the same cycle the request is presented. It appears as an error where a forward was expected, a forward where a rejection was due, or leaked read data. A corrupted policy register appears one cycle after the configuration write that caused it. It shows as a changed decision on some address in a sweep, so the bench tries every mirror, both directions and both trust levels around each programmed boundary. A configuration write that should have been ignored but was not shows as a decision change on the next sweep.

// File: rtl/mpf_pkg.sv
// Shared constants and policy type for the alias-aware protection filter.
// Assumes a 16 KB span made of four mirrors of a 4 KB window.
package mpf_pkg;
    localparam int OFF_W     = 12;
    localparam int ADDR_W    = 14;
    localparam int MIR_W     = ADDR_W - OFF_W;
    localparam int CFG_SEL_W = 3;

    // Configuration field selects.
    typedef enum logic [CFG_SEL_W-1:0] {
        SEL_BASE  = 3'd0,
        SEL_LIMIT = 3'd1,
        SEL_PERM  = 3'd2,
        SEL_ALIAS = 3'd3,
        SEL_SPAN  = 3'd4
    } cfg_sel_e;

    // Programmed access policy.
    typedef struct packed {
        logic [OFF_W-1:0] base;
        logic [OFF_W-1:0] limit;
        logic [OFF_W-1:0] span_last;
        logic             rd_ok;
        logic             wr_ok;
        logic             mirror_en;
        logic             mirror_block;
    } policy_t;

    // Fully locked state applied at reset.
    localparam policy_t POLICY_RESET = '{
        base:         '0,
        limit:        '1,
        span_last:    '1,
        rd_ok:        1'b0,
        wr_ok:        1'b0,
        mirror_en:    1'b0,
        mirror_block: 1'b1
    };
endpackage

// File: rtl/mpf_cfg_regs.sv
// Policy register file. Only writes flagged trusted are applied; untrusted
// writes and unknown selects leave the policy untouched.
// Assumes a synchronous active-low reset.
module mpf_cfg_regs
    import mpf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_trusted,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [OFF_W-1:0]     cfg_wdata,
    output policy_t              policy_q
);
    // Hold the policy; apply trusted writes to the selected field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            policy_q <= POLICY_RESET;
        end else if (cfg_we && cfg_trusted) begin
            case (cfg_sel)
                SEL_BASE:  policy_q.base      <= cfg_wdata;
                SEL_LIMIT: policy_q.limit     <= cfg_wdata;
                SEL_SPAN:  policy_q.span_last <= cfg_wdata;
                SEL_PERM: begin
                    policy_q.rd_ok <= cfg_wdata[0];
                    policy_q.wr_ok <= cfg_wdata[1];
                end
                SEL_ALIAS: begin
                    policy_q.mirror_en    <= cfg_wdata[0];
                    policy_q.mirror_block <= cfg_wdata[1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mpf_addr_fold.sv
// Splits an address into its canonical offset and a flag that says whether
// it hit a mirror copy rather than the primary window.
// Assumes ADDR_W >= OFF_W.
module mpf_addr_fold #(
    parameter int ADDR_W = 14,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [OFF_W-1:0]  offset,
    output logic              is_mirror
);
    localparam int MIR_W = ADDR_W - OFF_W;

    // Canonical offset is the low bits the unit decodes.
    always_comb offset = addr[OFF_W-1:0];

    generate
        if (MIR_W > 0) begin : g_mirrored
            // Any nonzero high bit selects a mirror copy.
            always_comb is_mirror = |addr[ADDR_W-1:OFF_W];
        end else begin : g_flat
            // No mirror bits: every address is primary.
            always_comb is_mirror = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mpf_policy.sv
// Access decision on the folded offset. Map-level checks (mirror disabled,
// beyond window size) apply to everyone; policy checks only to untrusted.
// Assumes the offset is already canonical.
module mpf_policy
    import mpf_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  logic             is_mirror,
    input  logic             write,
    input  logic             trusted,
    input  policy_t          policy,
    output logic             deny
);
    logic map_fault;
    logic in_range;
    logic perm_fault;
    logic mirror_fault;

    // Address-map faults that hit trusted requesters too.
    always_comb map_fault = (is_mirror && !policy.mirror_en)
                          || (offset > policy.span_last);

    // Protected range test, both bounds included.
    always_comb in_range = (offset >= policy.base) && (offset <= policy.limit);

    // Permission fault per direction inside the protected range.
    always_comb perm_fault = in_range && (write ? !policy.wr_ok : !policy.rd_ok);

    // Mirrors blocked outright for untrusted requesters.
    always_comb mirror_fault = is_mirror && policy.mirror_block;

    // Final decision.
    always_comb deny = map_fault || (!trusted && (perm_fault || mirror_fault));
endmodule

// File: rtl/mpf_top.sv
// Alias-aware protection filter between a requester and a mirrored register
// unit. Rejected requests finish at once with an error; accepted ones go to
// the unit on the canonical offset and return its read data combinationally.
// Assumes the unit answers reads in the cycle it accepts a request.
module mpf_top
    import mpf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 req_trusted,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_err,
    output logic                 tgt_valid,
    input  logic                 tgt_ready,
    output logic [OFF_W-1:0]     tgt_offset,
    output logic                 tgt_write,
    output logic [DATA_W-1:0]    tgt_wdata,
    input  logic [DATA_W-1:0]    tgt_rdata,
    input  logic                 cfg_we,
    input  logic                 cfg_trusted,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [OFF_W-1:0]     cfg_wdata
);
    policy_t          policy_q;
    logic [OFF_W-1:0] offset;
    logic             is_mirror;
    logic             deny;

    mpf_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_trusted (cfg_trusted),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .policy_q    (policy_q)
    );

    mpf_addr_fold #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fold (
        .addr      (req_addr),
        .offset    (offset),
        .is_mirror (is_mirror)
    );

    mpf_policy u_pol (
        .offset    (offset),
        .is_mirror (is_mirror),
        .write     (req_write),
        .trusted   (req_trusted),
        .policy    (policy_q),
        .deny      (deny)
    );

    // Forward accepted requests on the canonical offset.
    always_comb begin
        tgt_valid  = req_valid && !deny;
        tgt_offset = offset;
        tgt_write  = req_write;
        tgt_wdata  = req_wdata;
    end

    // Rejections complete at once; forwards wait for the unit.
    always_comb begin
        req_ready = deny || tgt_ready;
        rsp_valid = req_valid && req_ready;
        rsp_err   = rsp_valid && deny;
        rsp_rdata = deny ? '0 : tgt_rdata;
    end
endmodule

// File: rtl/mpf_top_chk.sv
// Property checker for mpf_top, attached by bind. Observes ports and the
// policy register; drives nothing.
module mpf_top_chk
    import mpf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic                 req_trusted,
    input  logic                 rsp_valid,
    input  logic                 rsp_err,
    input  logic [DATA_W-1:0]    rsp_rdata,
    input  logic                 tgt_valid,
    input  logic                 tgt_ready,
    input  logic [OFF_W-1:0]     tgt_offset,
    input  logic                 cfg_we,
    input  logic                 cfg_trusted,
    input  policy_t              pol
);
    // R7
    deny_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (!tgt_valid && rsp_rdata == '0));

    // R1
    fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (tgt_offset == req_addr[OFF_W-1:0]));

    // R5
    mirror_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && !pol.mirror_en) |-> (req_addr[ADDR_W-1:OFF_W] == '0));

    // R6
    span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (tgt_offset <= pol.span_last));

    // R3
    rd_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && !req_trusted && !req_write
         && tgt_offset >= pol.base && tgt_offset <= pol.limit) |-> pol.rd_ok);

    // R4
    mirror_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid && !req_trusted && pol.mirror_block)
        |-> (req_addr[ADDR_W-1:OFF_W] == '0));

    // R8
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (req_ready == tgt_ready && rsp_valid == tgt_ready && req_valid));

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_trusted) |=> $stable(pol));

    // R10
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pol == POLICY_RESET));
endmodule

bind mpf_top mpf_top_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_trusted (req_trusted),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .tgt_valid   (tgt_valid),
    .tgt_ready   (tgt_ready),
    .tgt_offset  (tgt_offset),
    .cfg_we      (cfg_we),
    .cfg_trusted (cfg_trusted),
    .pol         (policy_q)
);

// File: tb/tb_mpf_top.sv
// Sweep bench for mpf_top: every mirror, both directions and both trust
// levels over boundary and strided offsets, under several policies.
module tb_mpf_top;
    import mpf_pkg::*;

    localparam int DATA_W = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic                 req_write = 1'b0;
    logic [DATA_W-1:0]    req_wdata = '0;
    logic                 req_trusted = 1'b0;
    logic                 rsp_valid;
    logic [DATA_W-1:0]    rsp_rdata;
    logic                 rsp_err;
    logic                 tgt_valid;
    logic                 tgt_ready = 1'b1;
    logic [OFF_W-1:0]     tgt_offset;
    logic                 tgt_write;
    logic [DATA_W-1:0]    tgt_wdata;
    logic [DATA_W-1:0]    tgt_rdata;
    logic                 cfg_we = 1'b0;
    logic                 cfg_trusted = 1'b0;
    logic [CFG_SEL_W-1:0] cfg_sel = '0;
    logic [OFF_W-1:0]     cfg_wdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    // Policy model, updated only by trusted configuration writes.
    logic [OFF_W-1:0] m_base, m_limit, m_span;
    logic             m_rd, m_wr, m_en, m_blk;

    always #2 clk = ~clk;

    // Register unit model: read data identifies the offset read.
    assign tgt_rdata = {20'hC3A5E, tgt_offset};

    mpf_top #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_trusted(req_trusted),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_offset(tgt_offset),
        .tgt_write(tgt_write), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
        .cfg_we(cfg_we), .cfg_trusted(cfg_trusted), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata)
    );

    // Expected rejection, from the requirements.
    function automatic bit exp_deny(logic [ADDR_W-1:0] a, bit wr, bit tr);
        logic [OFF_W-1:0] off = a[OFF_W-1:0];
        bit mir = (a[ADDR_W-1:OFF_W] != '0);
        if (mir && !m_en) return 1'b1;                    // R5
        if (off > m_span) return 1'b1;                    // R6
        if (tr) return 1'b0;                              // R3 trusted bypass
        if (mir && m_blk) return 1'b1;                    // R4
        if (off >= m_base && off <= m_limit)              // R2
            return wr ? !m_wr : !m_rd;                    // R3
        return 1'b0;
    endfunction

    task automatic reset_model();
        m_base = '0; m_limit = '1; m_span = '1;
        m_rd = 1'b0; m_wr = 1'b0; m_en = 1'b0; m_blk = 1'b1;
    endtask

    // One configuration write; model follows only trusted writes (R9).
    task automatic cfg_write(logic [CFG_SEL_W-1:0] sel, logic [OFF_W-1:0] v, bit tr);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v; cfg_trusted = tr;
        @(posedge clk); #1;
        cfg_we = 1'b0; cfg_trusted = 1'b0;
        if (tr) begin
            case (sel)
                3'd0: m_base = v;
                3'd1: m_limit = v;
                3'd2: begin m_rd = v[0]; m_wr = v[1]; end
                3'd3: begin m_en = v[0]; m_blk = v[1]; end
                3'd4: m_span = v;
                default: ;
            endcase
        end
    endtask

    // Present one request, compare all outputs mid-cycle.
    task automatic access(logic [ADDR_W-1:0] a, bit wr, bit tr, string tag);
        bit d;
        logic [DATA_W+OFF_W+DATA_W+5:0] act, exp;
        req_addr = a; req_write = wr; req_trusted = tr;
        req_wdata = {18'h2B6C1, a}; req_valid = 1'b1;
        d = exp_deny(a, wr, tr);
        @(negedge clk);
        act = {req_ready, rsp_valid, rsp_err, rsp_rdata, tgt_valid,
               tgt_valid ? {tgt_write, tgt_offset, tgt_wdata} : {1'b0, {OFF_W{1'b0}}, {DATA_W{1'b0}}}};
        if (d)   // R7
            exp = {1'b1, 1'b1, 1'b1, {DATA_W{1'b0}}, 1'b0, 1'b0, {OFF_W{1'b0}}, {DATA_W{1'b0}}};
        else     // R1 R8
            exp = {tgt_ready, tgt_ready, 1'b0, {20'hC3A5E, a[OFF_W-1:0]}, 1'b1,
                   wr, a[OFF_W-1:0], {18'h2B6C1, a}};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0d tr=%0d actual=%h expected=%h",
                     tag, a, wr, tr, act, exp);
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Sweep mirrors, directions, trust over boundary and strided offsets.
    task automatic sweep(string tag);
        logic [OFF_W-1:0] offs [24];
        offs[0] = '0;          offs[1] = '1;
        offs[2] = m_base - 1;  offs[3] = m_base;
        offs[4] = m_limit;     offs[5] = m_limit + 1;
        offs[6] = m_span;      offs[7] = m_span + 1;
        for (int k = 0; k < 16; k++)
            offs[8+k] = OFF_W'(k * 256 + (k * 37) % 256);
        for (int o = 0; o < 24; o++)
            for (int m = 0; m < 4; m++)
                for (int w = 0; w < 2; w++)
                    for (int t = 0; t < 2; t++)
                        access({m[MIR_W-1:0], offs[o]}, w[0], t[0], tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        reset_model();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: idle outputs after reset.
        @(negedge clk);
        n_tests++;
        if (rsp_valid !== 1'b0 || tgt_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 idle actual=%b%b expected=00", rsp_valid, tgt_valid);
        end
        @(posedge clk); #1;

        // R10: locked reset policy.
        sweep("R10 reset policy");

        // R9: untrusted writes, including mirror controls and size, ignored.
        cfg_write(3'd3, 12'h001, 1'b0);
        cfg_write(3'd4, 12'h0FF, 1'b0);
        cfg_write(3'd2, 12'h003, 1'b0);
        cfg_write(3'd1, 12'h000, 1'b0);
        sweep("R9 untrusted cfg ignored");

        // R1 R2 R3: mirrors open, reads allowed, writes denied in range.
        cfg_write(3'd0, 12'h100, 1'b1);
        cfg_write(3'd1, 12'h2FF, 1'b1);
        cfg_write(3'd2, 12'h001, 1'b1);
        cfg_write(3'd3, 12'h001, 1'b1);
        sweep("R1 R2 R3 mirrored policy");

        // R4: mirror blocking with writes allowed, reads denied.
        cfg_write(3'd2, 12'h002, 1'b1);
        cfg_write(3'd3, 12'h003, 1'b1);
        sweep("R4 mirror block");

        // R6: smaller window, unknown select ignored (R9).
        cfg_write(3'd4, 12'h7FF, 1'b1);
        cfg_write(3'd0, 12'h400, 1'b1);
        cfg_write(3'd1, 12'h5FF, 1'b1);
        cfg_write(3'd2, 12'h000, 1'b1);
        cfg_write(3'd3, 12'h001, 1'b1);
        cfg_write(3'd6, 12'hFFF, 1'b1);
        sweep("R6 window size");

        // R2: base above limit protects nothing.
        cfg_write(3'd0, 12'h900, 1'b1);
        cfg_write(3'd1, 12'h100, 1'b1);
        cfg_write(3'd4, 12'hFFF, 1'b1);
        sweep("R2 empty range");

        // R5: mirrors disabled, trusted also rejected on bits 13:12.
        cfg_write(3'd3, 12'h000, 1'b1);
        sweep("R5 mirror disabled");

        // R7 R8: target stalls; forwards wait, rejections complete.
        tgt_ready = 1'b0;
        access(14'h0010, 1'b0, 1'b1, "R8 stall forward");
        access(14'h1010, 1'b0, 1'b1, "R7 stall reject");
        tgt_ready = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule